// File: doc/BRIEF.md
# Instruction Prefix State Decoder

This block sits between the instruction fetch path and the execute stage of a 16-bit coprocessor. Several one-byte prefix instructions change how the next opcode behaves. Three prefixes choose an alternate mode, two choose the source or the destination register pointer, and one chooses both pointers and binds them. The decoder takes the fetched bytes one at a time under a valid strobe and keeps this prefix state across fetches. When a real instruction arrives, it issues that instruction with the pending mode and the two register indices, and then clears the prefix state.

A bind prefix (register-pair select) changes the meaning of the bytes that follow it. After a bind, a destination-select or source-select byte is no longer a prefix. It becomes a register-to-register move: a plain move or a move that updates flags. The live mode and bind bits are exported so that a status register can mirror them.

The state machine has three states. `ST_IDLE` means no prefix is pending. `ST_ARMED` means a mode or pointer prefix is pending without a bind. `ST_BOUND` means a bind is pending.

The transitions are:
- `T_ARM`: a mode, source-select or destination-select byte moves `ST_IDLE` to `ST_ARMED`.
- `T_BIND`: a bind byte moves any state to `ST_BOUND`.
- `T_ISSUE`: a real instruction moves any state to `ST_IDLE`.
- `T_MOVE`: a select byte in `ST_BOUND` moves it to `ST_IDLE` and issues a move.
- `T_HOLD`: a mode byte in `ST_ARMED` or `ST_BOUND`, or no valid byte, keeps the state.

Top module: `prefix_state_decoder`

## Requirements
- R1: After reset, no instruction is issued, both mode bits and the bind bit are 0, and both register pointers are 0.
- R2: Byte 0x3D sets the first mode bit, 0x3E sets the second and 0x3F sets both. Each is a prefix and issues nothing. The instruction mode field carries bit 0 = first mode and bit 1 = second mode.
- R3: A mode prefix never clears a mode bit that an earlier prefix set. 0x3D followed by 0x3E leaves both bits set.
- R4: Without a pending bind, byte 0xBn sets the source pointer to n and byte 0x1n sets the destination pointer to n. Neither issues anything.
- R5: Byte 0x2n sets both pointers to n and sets the bind bit. It issues nothing.
- R6: With a bind pending from 0x2n, byte 0x1m issues a move with source n, destination m, the move flag 1 and the flag-update bit 0.
- R7: With a bind pending from 0x2n, byte 0xBm issues a move with source n, destination m, the move flag 1 and the flag-update bit 1.
- R8: Any other byte is issued one clock after it is accepted. The issue carries the byte as opcode, the pending mode bits and the current source and destination pointers, with the move flag 0.
- R9: In the cycle an instruction is visible on the issue outputs, both mode bits and the bind bit are 0 and both pointers are back to 0.
- R10: While the fetch valid input is low, no instruction is issued and the prefix state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetched byte is present this cycle |
| fetch_byte | input | 2*IDX_W (8) | Fetched byte |
| instr_valid | output | 1 | An instruction is issued this cycle |
| instr_opcode | output | 2*IDX_W (8) | Opcode byte of the issued instruction |
| instr_alt | output | 2 | Mode bits in effect for the issued instruction |
| instr_src | output | IDX_W (4) | Source register index |
| instr_dst | output | IDX_W (4) | Destination register index |
| instr_is_move | output | 1 | Instruction is a bound register move |
| instr_move_flags | output | 1 | Bound move also updates flags |
| mode_alt1 | output | 1 | Live first mode bit |
| mode_alt2 | output | 1 | Live second mode bit |
| mode_bind | output | 1 | Live bind bit |

## Verification
The bench builds the block with the default 4-bit register index, which gives 8-bit fetch bytes. Under that width all sixteen pointer values and every opcode byte can be reached by the random phase. A behavioural model runs next to the design and is compared on every cycle. Directed sequences cover mode accumulation, binds followed by both kinds of move, pointer overrides, and idle gaps inside prefix chains. A long biased-random stream then mixes prefixes, real opcodes and idle cycles, so every state transition occurs many times.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [2:0] {
        BC_ALT,
        BC_FROM,
        BC_TO,
        BC_WITH,
        BC_PLAIN
    } byte_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BOUND
    } pfx_state_e;

endpackage

// File: rtl/psd_byte_classify.sv
module psd_byte_classify
    import psd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [2*IDX_W-1:0] byte_i,
    output byte_class_e        cls_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [1:0]         alt_set_o
);
    localparam int BYTE_W = 2 * IDX_W;
    localparam logic [IDX_W-1:0] HI_TO   = IDX_W'(1);
    localparam logic [IDX_W-1:0] HI_WITH = IDX_W'(2);
    localparam logic [IDX_W-1:0] HI_ALT  = IDX_W'(3);
    localparam logic [IDX_W-1:0] HI_FROM = IDX_W'(11);
    localparam logic [IDX_W-1:0] LO_ALT1 = IDX_W'(13);
    localparam logic [IDX_W-1:0] LO_ALT2 = IDX_W'(14);
    localparam logic [IDX_W-1:0] LO_ALT3 = IDX_W'(15);

    logic [IDX_W-1:0] hi;
    logic [IDX_W-1:0] lo;

    always_comb begin
        hi        = byte_i[BYTE_W-1:IDX_W];
        lo        = byte_i[IDX_W-1:0];
        idx_o     = lo;
        alt_set_o = 2'b00;
        cls_o     = BC_PLAIN;
        if (hi == HI_ALT && (lo == LO_ALT1 || lo == LO_ALT2 || lo == LO_ALT3)) begin
            cls_o     = BC_ALT;
            alt_set_o = {(lo == LO_ALT2 || lo == LO_ALT3), (lo == LO_ALT1 || lo == LO_ALT3)};
        end else if (hi == HI_FROM) begin
            cls_o = BC_FROM;
        end else if (hi == HI_TO) begin
            cls_o = BC_TO;
        end else if (hi == HI_WITH) begin
            cls_o = BC_WITH;
        end
    end

endmodule

// File: rtl/psd_prefix_fsm.sv
module psd_prefix_fsm
    import psd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  byte_class_e      in_cls,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [1:0]       in_alt_set,
    output logic             emit_o,
    output logic             emit_move_o,
    output logic             emit_flags_o,
    output logic [IDX_W-1:0] emit_src_o,
    output logic [IDX_W-1:0] emit_dst_o,
    output logic [1:0]       alt_o,
    output logic [IDX_W-1:0] src_o,
    output logic             bind_o
);
    pfx_state_e       state_q, state_n;
    logic [1:0]       alt_q, alt_n;
    logic [IDX_W-1:0] src_q, src_n;
    logic [IDX_W-1:0] dst_q, dst_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            alt_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_n;
            alt_q   <= alt_n;
            src_q   <= src_n;
            dst_q   <= dst_n;
        end
    end

    always_comb begin
        state_n      = state_q;
        alt_n        = alt_q;
        src_n        = src_q;
        dst_n        = dst_q;
        emit_o       = 1'b0;
        emit_move_o  = 1'b0;
        emit_flags_o = 1'b0;
        emit_src_o   = src_q;
        emit_dst_o   = dst_q;
        if (in_valid) begin
            unique case (in_cls)
                BC_ALT: begin
                    alt_n = alt_q | in_alt_set;
                    if (state_q == ST_IDLE) state_n = ST_ARMED;
                end
                BC_WITH: begin
                    src_n   = in_idx;
                    dst_n   = in_idx;
                    state_n = ST_BOUND;
                end
                BC_FROM, BC_TO: begin
                    if (state_q == ST_BOUND) begin
                        emit_o       = 1'b1;
                        emit_move_o  = 1'b1;
                        emit_flags_o = (in_cls == BC_FROM);
                        emit_dst_o   = in_idx;
                    end else begin
                        if (in_cls == BC_FROM) src_n = in_idx;
                        else                   dst_n = in_idx;
                        state_n = ST_ARMED;
                    end
                end
                BC_PLAIN: begin
                    emit_o = 1'b1;
                end
                default: ;
            endcase
            if (emit_o) begin
                state_n = ST_IDLE;
                alt_n   = '0;
                src_n   = '0;
                dst_n   = '0;
            end
        end
    end

    assign alt_o  = alt_q;
    assign src_o  = src_q;
    assign bind_o = (state_q == ST_BOUND);

    p_idle_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (alt_q == 2'b00 && src_q == '0 && dst_q == '0));

endmodule

// File: rtl/psd_issue_reg.sv
module psd_issue_reg #(
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               emit_i,
    input  logic [2*IDX_W-1:0] op_i,
    input  logic [1:0]         alt_i,
    input  logic [IDX_W-1:0]   src_i,
    input  logic [IDX_W-1:0]   dst_i,
    input  logic               move_i,
    input  logic               flags_i,
    output logic               valid_o,
    output logic [2*IDX_W-1:0] op_o,
    output logic [1:0]         alt_o,
    output logic [IDX_W-1:0]   src_o,
    output logic [IDX_W-1:0]   dst_o,
    output logic               move_o,
    output logic               flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            op_o    <= '0;
            alt_o   <= '0;
            src_o   <= '0;
            dst_o   <= '0;
            move_o  <= 1'b0;
            flags_o <= 1'b0;
        end else begin
            valid_o <= emit_i;
            if (emit_i) begin
                op_o    <= op_i;
                alt_o   <= alt_i;
                src_o   <= src_i;
                dst_o   <= dst_i;
                move_o  <= move_i;
                flags_o <= flags_i;
            end
        end
    end

    p_flags_need_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && flags_o) |-> move_o);

endmodule

// File: rtl/prefix_state_decoder.sv
module prefix_state_decoder
    import psd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [2*IDX_W-1:0] fetch_byte,
    output logic               instr_valid,
    output logic [2*IDX_W-1:0] instr_opcode,
    output logic [1:0]         instr_alt,
    output logic [IDX_W-1:0]   instr_src,
    output logic [IDX_W-1:0]   instr_dst,
    output logic               instr_is_move,
    output logic               instr_move_flags,
    output logic               mode_alt1,
    output logic               mode_alt2,
    output logic               mode_bind
);
    byte_class_e      cls;
    logic [IDX_W-1:0] idx;
    logic [1:0]       alt_set;
    logic             emit, emit_move, emit_flags;
    logic [IDX_W-1:0] emit_src, emit_dst, cur_src;
    logic [1:0]       cur_alt;

    psd_byte_classify #(.IDX_W(IDX_W)) u_cls (
        .byte_i    (fetch_byte),
        .cls_o     (cls),
        .idx_o     (idx),
        .alt_set_o (alt_set)
    );

    psd_prefix_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (fetch_valid),
        .in_cls       (cls),
        .in_idx       (idx),
        .in_alt_set   (alt_set),
        .emit_o       (emit),
        .emit_move_o  (emit_move),
        .emit_flags_o (emit_flags),
        .emit_src_o   (emit_src),
        .emit_dst_o   (emit_dst),
        .alt_o        (cur_alt),
        .src_o        (cur_src),
        .bind_o       (mode_bind)
    );

    psd_issue_reg #(.IDX_W(IDX_W)) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .emit_i  (emit),
        .op_i    (fetch_byte),
        .alt_i   (cur_alt),
        .src_i   (emit_src),
        .dst_i   (emit_dst),
        .move_i  (emit_move),
        .flags_i (emit_flags),
        .valid_o (instr_valid),
        .op_o    (instr_opcode),
        .alt_o   (instr_alt),
        .src_o   (instr_src),
        .dst_o   (instr_dst),
        .move_o  (instr_is_move),
        .flags_o (instr_move_flags)
    );

    assign mode_alt1 = cur_alt[0];
    assign mode_alt2 = cur_alt[1];

    p_prefix_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && (cls == BC_ALT || cls == BC_WITH)) |=> !instr_valid);

    p_alt_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && cls == BC_ALT && mode_alt1) |=> mode_alt1);

    p_with_binds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && cls == BC_WITH) |=> mode_bind);

    p_move_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && mode_bind && cls == BC_TO) |=>
        (instr_valid && instr_is_move && !instr_move_flags && instr_src == $past(cur_src)));

    p_clear_on_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (!mode_alt1 && !mode_alt2 && !mode_bind && cur_src == '0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!instr_valid && $stable({mode_alt1, mode_alt2, mode_bind, cur_src})));

endmodule

// File: tb/prefix_state_decoder_test.sv
module prefix_state_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_valid = 1'b0;
    logic [7:0] fetch_byte = 8'h00;
    logic       instr_valid;
    logic [7:0] instr_opcode;
    logic [1:0] instr_alt;
    logic [3:0] instr_src, instr_dst;
    logic       instr_is_move, instr_move_flags;
    logic       mode_alt1, mode_alt2, mode_bind;

    prefix_state_decoder #(.IDX_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
        .instr_valid(instr_valid), .instr_opcode(instr_opcode), .instr_alt(instr_alt),
        .instr_src(instr_src), .instr_dst(instr_dst), .instr_is_move(instr_is_move),
        .instr_move_flags(instr_move_flags), .mode_alt1(mode_alt1), .mode_alt2(mode_alt2),
        .mode_bind(mode_bind)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    int m_a1 = 0, m_a2 = 0, m_bind = 0, m_src = 0, m_dst = 0;
    int e_valid = 0, e_op = 0, e_alt = 0, e_src = 0, e_dst = 0, e_move = 0, e_fl = 0;
    string tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a1 = 0; m_a2 = 0; m_bind = 0; m_src = 0; m_dst = 0;
            e_valid = 0; tag = "R1";
        end else begin
            e_valid = 0;
            if (!fetch_valid) begin
                tag = "R10";
            end else begin
                int b, hi, lo;
                b = fetch_byte; hi = b / 16; lo = b % 16;
                if (b == 8'h3D || b == 8'h3E || b == 8'h3F) begin
                    tag = (m_a1 || m_a2) ? "R3" : "R2";
                    if (b != 8'h3E) m_a1 = 1;
                    if (b != 8'h3D) m_a2 = 1;
                end else if (hi == 2) begin
                    tag = "R5"; m_src = lo; m_dst = lo; m_bind = 1;
                end else if ((hi == 1 || hi == 11) && m_bind == 1) begin
                    tag = (hi == 11) ? "R7" : "R6";
                    e_valid = 1; e_op = b; e_alt = m_a2 * 2 + m_a1;
                    e_src = m_src; e_dst = lo; e_move = 1; e_fl = (hi == 11);
                end else if (hi == 11) begin
                    tag = "R4"; m_src = lo;
                end else if (hi == 1) begin
                    tag = "R4"; m_dst = lo;
                end else begin
                    tag = "R8";
                    e_valid = 1; e_op = b; e_alt = m_a2 * 2 + m_a1;
                    e_src = m_src; e_dst = m_dst; e_move = 0; e_fl = 0;
                end
                if (e_valid) begin
                    m_a1 = 0; m_a2 = 0; m_bind = 0; m_src = 0; m_dst = 0;
                end
            end
        end
    end

    task automatic chk(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            chk(tag, "instr_valid", int'(instr_valid), e_valid);
            if (e_valid) begin
                chk(tag, "opcode", int'(instr_opcode), e_op);
                chk(tag, "alt", int'(instr_alt), e_alt);
                chk(tag, "src", int'(instr_src), e_src);
                chk(tag, "dst", int'(instr_dst), e_dst);
                chk(tag, "is_move", int'(instr_is_move), e_move);
                chk(tag, "move_flags", int'(instr_move_flags), e_fl);
            end
            chk(e_valid ? "R9" : tag, "mode_alt1", int'(mode_alt1), m_a1);
            chk(e_valid ? "R9" : tag, "mode_alt2", int'(mode_alt2), m_a2);
            chk(e_valid ? "R9" : tag, "mode_bind", int'(mode_bind), m_bind);
        end
    end

    task automatic put(input logic v, input logic [7:0] b);
        @(negedge clk);
        fetch_valid = v;
        fetch_byte  = b;
    endtask

    function automatic bit is_pfx(input logic [7:0] b);
        return (b[7:4] == 4'h1) || (b[7:4] == 4'h2) || (b[7:4] == 4'hB) ||
               (b == 8'h3D) || (b == 8'h3E) || (b == 8'h3F);
    endfunction

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 / R3: mode accumulation, then an ADD-class opcode
        put(1, 8'h3D); put(1, 8'h3E); put(0, 8'h00); put(1, 8'h57);
        put(1, 8'h3F); put(1, 8'h5A);
        put(1, 8'h3E); put(1, 8'h50);
        // R4: pointer prefixes then a real opcode; later select overrides
        put(1, 8'hB3); put(1, 8'h1C); put(1, 8'h1D); put(1, 8'h6F);
        // R5 / R6: bind then plain move
        put(1, 8'h25); put(1, 8'h1A);
        // R5 / R7: bind then flag-setting move, with mode in between
        put(1, 8'h26); put(1, 8'h3D); put(0, 8'hB9); put(1, 8'hB9);
        // rebind overrides, then plain opcode keeps bound pointers
        put(1, 8'h21); put(1, 8'h2F); put(1, 8'h4E);
        // R10: idle stretch inside a prefix chain
        put(1, 8'hB7); put(0, 8'h50); put(0, 8'h3F); put(1, 8'h00);
        // R9: back-to-back real opcodes after a cleared state
        put(1, 8'h3F); put(1, 8'hDF); put(1, 8'h01);
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] b;
            int k;
            k = $urandom % 9;
            b = 8'($urandom);
            case (k)
                0: put(1, 8'h3D + 8'($urandom % 3));
                1: put(1, {4'hB, b[3:0]});
                2: put(1, {4'h1, b[3:0]});
                3: put(1, {4'h2, b[3:0]});
                4: put(0, b);
                default: begin
                    while (is_pfx(b)) b = 8'($urandom);
                    put(1, b);
                end
            endcase
        end
        put(0, 8'h00); put(0, 8'h00); put(0, 8'h00);
        @(posedge clk);
        @(negedge clk);
        #1;
        finish_run();
    end
endmodule